// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block is the single-operand shift and rotate stage of an integer execution pipeline. Each cycle it takes a 32-bit operand, a 3-bit operation code, the current carry flag and two count candidates: an immediate byte and the low byte of a count register. A source selector picks the immediate, the constant one or the register byte. The chosen count is masked to its low five bits, and the operation is applied.

The unit supports seven operations: rotate left and right, rotate left and right through carry (a 33-bit rotate that includes the carry flag), logical shift left and right, and arithmetic shift right. The result and all flag outputs are registered, so they appear one clock after the inputs. Separate write enables tell the register file and the flag logic what to commit. Rotates only touch carry and overflow. Shifts also produce sign, zero, auxiliary and parity flags. A masked count of zero commits nothing.

Top module: `shrot_unit`

## Requirements
- R1: The count is taken from `imm_i` when `csrc_i` is 0, is the constant 1 when `csrc_i` is 1, and comes from `creg_i` when `csrc_i` is 2 or 3. Only the low 5 bits of the chosen value are used.
- R2: With a masked count of zero, `res_o` equals the operand and `cf_o` equals `cf_i`. `res_we_o`, `cof_we_o` and `szap_we_o` are all 0, and `of_o`, `sf_o`, `zf_o`, `af_o` and `pf_o` are 0.
- R3: Op 0 (rotate left by n) gives the operand rotated left by n. `cf_o` is result bit 0, and `of_o` is `cf_o` XOR result bit 31.
- R4: Op 1 (rotate right by n) gives the operand rotated right by n. `cf_o` is result bit 31, and `of_o` is result bit 31 XOR result bit 30.
- R5: Op 2 rotates the 33-bit value {carry, operand} left by n. The old carry lands at bit n-1, and the new carry is operand bit 32-n. `of_o` is the new carry XOR result bit 31.
- R6: Op 3 rotates {carry, operand} right by n. The old carry lands at bit 32-n, and the new carry is operand bit n-1. `of_o` is result bit 31 XOR result bit 30.
- R7: Ops 4 and 6 shift left by n and fill the low bits with zeros. `cf_o` is the last bit shifted out (operand bit 32-n).
- R8: Op 5 shifts right logically and fills the high bits with zeros. Op 7 shifts right and fills the high bits with the original bit 31. For both, `cf_o` is operand bit n-1.
- R9: For a shift with nonzero count: `sf_o` is result bit 31 and `zf_o` is 1 exactly when the result is zero. `pf_o` is 1 when the low result byte has an even number of ones, `af_o` is 0, and `szap_we_o` is 1.
- R10: For a shift with nonzero count, `of_o` depends on the operation. For a left shift it is result bit 31 XOR `cf_o`. For a logical right shift it is the original bit 31. For an arithmetic right shift it is 0.
- R11: For a rotate with nonzero count, `res_we_o` and `cof_we_o` are 1, `szap_we_o` is 0, and `sf_o`, `zf_o`, `af_o` and `pf_o` are 0. For a shift with nonzero count, `res_we_o` and `cof_we_o` are also 1.
- R12: Outputs reflect the inputs sampled at the previous rising clock edge. While `rst` is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operand_i | input | 32 | Value to shift or rotate |
| op_i | input | 3 | Operation code (0 ROL, 1 ROR, 2 RCL, 3 RCR, 4/6 SHL, 5 SHR, 7 SAR) |
| cf_i | input | 1 | Incoming carry flag |
| imm_i | input | 8 | Immediate count byte |
| creg_i | input | 8 | Low byte of the count register |
| csrc_i | input | 2 | Count source select |
| res_o | output | 32 | Result |
| res_we_o | output | 1 | Result write enable |
| cf_o | output | 1 | Carry flag out |
| of_o | output | 1 | Overflow flag out |
| cof_we_o | output | 1 | Carry/overflow write enable |
| szap_we_o | output | 1 | Sign/zero/aux/parity write enable |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| af_o | output | 1 | Auxiliary flag |
| pf_o | output | 1 | Parity flag |

## Verification
The delicate overlap is the incoming carry meeting a zero count. A rotate-through-carry would normally consume the carry and replace it, while the zero-count rule must pass the carry through untouched and suppress every write enable. The sweep drives each operation at every count from 0 to 31 with both carry values, so each operation meets the zero-count case with carry set and with carry clear. Every output is judged against a bench model that rotates or shifts one bit at a time. Further directed vectors feed a count register byte whose low five bits are zero, to confirm that masking creates the same zero-count case.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_ROL     = 3'd0,
        OP_ROR     = 3'd1,
        OP_RCL     = 3'd2,
        OP_RCR     = 3'd3,
        OP_SHL     = 3'd4,
        OP_SHR     = 3'd5,
        OP_SHL_ALT = 3'd6,
        OP_SAR     = 3'd7
    } sr_op_e;

    typedef enum logic [1:0] {
        CS_IMM     = 2'd0,
        CS_ONE     = 2'd1,
        CS_REG     = 2'd2,
        CS_REG_ALT = 2'd3
    } cnt_src_e;

    typedef struct packed {
        logic cf;
        logic of;
        logic cof_we;
        logic szap_we;
        logic sf;
        logic zf;
        logic af;
        logic pf;
    } sr_flags_t;

    function automatic logic is_rotate(sr_op_e op);
        return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
    endfunction

    function automatic logic even_ones(logic [7:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/shrot_count_sel.sv
module shrot_count_sel
    import shrot_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned BW = 8,
    localparam int unsigned CW = $clog2(W)
) (
    input  cnt_src_e        src,
    input  logic [BW-1:0]   imm,
    input  logic [BW-1:0]   creg,
    output logic [CW-1:0]   cnt
);
    logic [BW-1:0] raw;

    always_comb begin
        case (src)
            CS_IMM:  raw = imm;
            CS_ONE:  raw = BW'(1);
            default: raw = creg;
        endcase
        cnt = raw[CW-1:0];
    end
endmodule

// File: rtl/shrot_rotator.sv
module shrot_rotator
    import shrot_pkg::*;
#(
    parameter int unsigned W = 32,
    localparam int unsigned CW = $clog2(W),
    localparam int unsigned W1 = W + 1
) (
    input  sr_op_e          op,
    input  logic [W-1:0]    a,
    input  logic            cf_in,
    input  logic [CW-1:0]   n,
    output logic [W-1:0]    r,
    output logic            cf_n,
    output logic            of_n
);
    logic [2*W-1:0]  dl, dr;
    logic [2*W1-1:0] el, er;
    logic [W1-1:0]   x, y;

    always_comb begin
        x  = {cf_in, a};
        dl = {a, a} << n;
        dr = {a, a} >> n;
        el = {x, x} << n;
        er = {x, x} >> n;
        y  = '0;
        r  = a;
        cf_n = cf_in;
        of_n = 1'b0;
        case (op)
            OP_ROL: begin
                r    = dl[2*W-1:W];
                cf_n = r[0];
                of_n = r[0] ^ r[W-1];
            end
            OP_ROR: begin
                r    = dr[W-1:0];
                cf_n = r[W-1];
                of_n = r[W-1] ^ r[W-2];
            end
            OP_RCL: begin
                y    = el[2*W1-1:W1];
                r    = y[W-1:0];
                cf_n = y[W];
                of_n = y[W] ^ y[W-1];
            end
            OP_RCR: begin
                y    = er[W1-1:0];
                r    = y[W-1:0];
                cf_n = y[W];
                of_n = y[W-1] ^ y[W-2];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/shrot_shifter.sv
module shrot_shifter
    import shrot_pkg::*;
#(
    parameter int unsigned W = 32,
    localparam int unsigned CW = $clog2(W)
) (
    input  sr_op_e          op,
    input  logic [W-1:0]    a,
    input  logic [CW-1:0]   n,
    output logic [W-1:0]    r,
    output logic            cf_n,
    output logic            of_n,
    output logic            sf,
    output logic            zf,
    output logic            af,
    output logic            pf
);
    logic [W:0] sl, srl, sra;

    always_comb begin
        sl  = {1'b0, a} << n;
        srl = {a, 1'b0} >> n;
        sra = $signed({a, 1'b0}) >>> n;
        case (op)
            OP_SHR: begin
                r    = srl[W:1];
                cf_n = srl[0];
                of_n = a[W-1];
            end
            OP_SAR: begin
                r    = sra[W:1];
                cf_n = sra[0];
                of_n = 1'b0;
            end
            default: begin
                r    = sl[W-1:0];
                cf_n = sl[W];
                of_n = sl[W] ^ sl[W-1];
            end
        endcase
        sf = r[W-1];
        zf = ~|r;
        af = 1'b0;
        pf = even_ones(r[7:0]);
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned BW = 8,
    localparam int unsigned CW = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W-1:0]    operand_i,
    input  logic [2:0]      op_i,
    input  logic            cf_i,
    input  logic [BW-1:0]   imm_i,
    input  logic [BW-1:0]   creg_i,
    input  logic [1:0]      csrc_i,
    output logic [W-1:0]    res_o,
    output logic            res_we_o,
    output logic            cf_o,
    output logic            of_o,
    output logic            cof_we_o,
    output logic            szap_we_o,
    output logic            sf_o,
    output logic            zf_o,
    output logic            af_o,
    output logic            pf_o
);
    sr_op_e        op;
    logic [CW-1:0] cnt;
    logic [W-1:0]  rot_r, sh_r, nxt_res;
    logic          rot_cf, rot_of, sh_cf, sh_of;
    logic          sh_sf, sh_zf, sh_af, sh_pf;
    logic          nxt_we;
    sr_flags_t     nxt_fl, fl_q;
    logic [W-1:0]  res_q;
    logic          we_q;

    assign op = sr_op_e'(op_i);

    shrot_count_sel #(.W(W), .BW(BW)) u_cnt (
        .src  (cnt_src_e'(csrc_i)),
        .imm  (imm_i),
        .creg (creg_i),
        .cnt  (cnt)
    );

    shrot_rotator #(.W(W)) u_rot (
        .op    (op),
        .a     (operand_i),
        .cf_in (cf_i),
        .n     (cnt),
        .r     (rot_r),
        .cf_n  (rot_cf),
        .of_n  (rot_of)
    );

    shrot_shifter #(.W(W)) u_sh (
        .op   (op),
        .a    (operand_i),
        .n    (cnt),
        .r    (sh_r),
        .cf_n (sh_cf),
        .of_n (sh_of),
        .sf   (sh_sf),
        .zf   (sh_zf),
        .af   (sh_af),
        .pf   (sh_pf)
    );

    always_comb begin
        nxt_fl    = '0;
        nxt_fl.cf = cf_i;
        nxt_res   = operand_i;
        nxt_we    = 1'b0;
        if (cnt != '0) begin
            nxt_we        = 1'b1;
            nxt_fl.cof_we = 1'b1;
            if (is_rotate(op)) begin
                nxt_res   = rot_r;
                nxt_fl.cf = rot_cf;
                nxt_fl.of = rot_of;
            end else begin
                nxt_res        = sh_r;
                nxt_fl.cf      = sh_cf;
                nxt_fl.of      = sh_of;
                nxt_fl.szap_we = 1'b1;
                nxt_fl.sf      = sh_sf;
                nxt_fl.zf      = sh_zf;
                nxt_fl.af      = sh_af;
                nxt_fl.pf      = sh_pf;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            we_q  <= 1'b0;
            fl_q  <= '0;
        end else begin
            res_q <= nxt_res;
            we_q  <= nxt_we;
            fl_q  <= nxt_fl;
        end
    end

    assign res_o     = res_q;
    assign res_we_o  = we_q;
    assign cf_o      = fl_q.cf;
    assign of_o      = fl_q.of;
    assign cof_we_o  = fl_q.cof_we;
    assign szap_we_o = fl_q.szap_we;
    assign sf_o      = fl_q.sf;
    assign zf_o      = fl_q.zf;
    assign af_o      = fl_q.af;
    assign pf_o      = fl_q.pf;

    // Qualifies checks that look one cycle back across reset release.
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_zero_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (armed && !res_we_o) |-> (res_o == $past(operand_i) && cf_o == $past(cf_i)
                                  && !cof_we_o && !szap_we_o));

    assert_rotate_keeps_szap_R11: assert property (@(posedge clk) disable iff (rst)
        (armed && is_rotate(sr_op_e'($past(op_i)))) |-> !szap_we_o);

    assert_flag_we_needs_res_we_R11: assert property (@(posedge clk) disable iff (rst)
        (cof_we_o || szap_we_o) |-> res_we_o);

    assert_sar_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (armed && szap_we_o && $past(op_i) == 3'd7) |-> !of_o);

    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (rst)
        szap_we_o |-> (zf_o == (res_o == '0)));

    assert_reset_clear_R12: assert property (@(posedge clk)
        $past(rst) |-> (!res_we_o && res_o == '0));
endmodule

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
    localparam int CLK_P = 10;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [W-1:0]  operand_i;
    logic [2:0]    op_i;
    logic          cf_i;
    logic [7:0]    imm_i, creg_i;
    logic [1:0]    csrc_i;
    logic [W-1:0]  res_o;
    logic          res_we_o, cf_o, of_o, cof_we_o, szap_we_o, sf_o, zf_o, af_o, pf_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    shrot_unit dut (
        .clk(clk), .rst(rst), .operand_i(operand_i), .op_i(op_i), .cf_i(cf_i),
        .imm_i(imm_i), .creg_i(creg_i), .csrc_i(csrc_i), .res_o(res_o),
        .res_we_o(res_we_o), .cf_o(cf_o), .of_o(of_o), .cof_we_o(cof_we_o),
        .szap_we_o(szap_we_o), .sf_o(sf_o), .zf_o(zf_o), .af_o(af_o), .pf_o(pf_o)
    );

    // Packed view: res, res_we, cf, of, cof_we, szap_we, sf, zf, af, pf
    function automatic logic [W+8:0] observed();
        return {res_o, res_we_o, cf_o, of_o, cof_we_o, szap_we_o, sf_o, zf_o, af_o, pf_o};
    endfunction

    // One-bit-at-a-time model of the requirements.
    function automatic logic [W+8:0] model(input logic [2:0] op, input logic [W-1:0] a,
                                           input logic c, input int n);
        logic [W-1:0] r;
        logic cc, of, szap, sf, zf, pf;
        r = a; cc = c; of = 1'b0; szap = 1'b0; sf = 1'b0; zf = 1'b0; pf = 1'b0;
        if (n == 0) return {a, 1'b0, c, 7'b0};
        for (int k = 0; k < n; k++) begin
            case (op)
                3'd0: begin cc = r[W-1]; r = {r[W-2:0], r[W-1]}; end
                3'd1: begin cc = r[0];   r = {r[0], r[W-1:1]}; end
                3'd2: begin {cc, r} = {r, cc}; end
                3'd3: begin {r, cc} = {cc, r}; end
                3'd5: begin cc = r[0];   r = {1'b0, r[W-1:1]}; end
                3'd7: begin cc = r[0];   r = {r[W-1], r[W-1:1]}; end
                default: begin cc = r[W-1]; r = {r[W-2:0], 1'b0}; end
            endcase
        end
        case (op)
            3'd0, 3'd2: of = cc ^ r[W-1];
            3'd1, 3'd3: of = r[W-1] ^ r[W-2];
            3'd5:       of = a[W-1];
            3'd7:       of = 1'b0;
            default:    of = r[W-1] ^ cc;
        endcase
        if (op >= 3'd4) begin
            szap = 1'b1;
            sf = r[W-1];
            zf = (r == '0);
            pf = 1'b1;
            for (int k = 0; k < 8; k++) pf = pf ^ r[k];
        end
        return {r, 1'b1, cc, of, 1'b1, szap, sf, zf, 1'b0, pf};
    endfunction

    function automatic string tag_of(input logic [2:0] op, input int n);
        if (n == 0) return "R2";
        case (op)
            3'd0: return "R3/R11";
            3'd1: return "R4/R11";
            3'd2: return "R5/R11";
            3'd3: return "R6/R11";
            3'd5, 3'd7: return "R8/R9/R10";
            default: return "R7/R9/R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W+8:0] got, input logic [W+8:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge; result registered at the next rising edge; sample at the following falling edge.
    task automatic apply(input logic [2:0] op, input logic [W-1:0] a, input logic c,
                         input logic [7:0] imm, input logic [7:0] creg, input logic [1:0] src);
        operand_i = a; op_i = op; cf_i = c; imm_i = imm; creg_i = creg; csrc_i = src;
        @(negedge clk);
    endtask

    logic [W-1:0] pats [5] = '{32'h8000_0001, 32'h7F3C_A5E1, 32'hFFFF_FFFF,
                               32'h0000_0000, 32'h4000_0080};

    initial begin
        rst = 1'b1;
        operand_i = '0; op_i = '0; cf_i = 1'b0; imm_i = '0; creg_i = '0; csrc_i = '0;
        @(negedge clk); @(negedge clk);
        // R12: outputs cleared during reset
        check("R12 reset", observed(), '0);
        rst = 1'b0;

        // Full sweep: every op, every count, both carries, several operands (R2..R11).
        for (int p = 0; p < 5; p++)
            for (int o = 0; o < 8; o++)
                for (int n = 0; n < 32; n++)
                    for (int c = 0; c < 2; c++) begin
                        apply(3'(o), pats[p], 1'(c), 8'(n), 8'h00, 2'd0);
                        check(tag_of(3'(o), n), observed(), model(3'(o), pats[p], 1'(c), n));
                    end

        // R1: count source selection and masking
        apply(3'd0, 32'h1234_5678, 1'b0, 8'h00, 8'h1F, 2'd1);
        check("R1 const-one", observed(), model(3'd0, 32'h1234_5678, 1'b0, 1));
        apply(3'd4, 32'h1234_5678, 1'b1, 8'h07, 8'hE3, 2'd2);
        check("R1 reg-masked", observed(), model(3'd4, 32'h1234_5678, 1'b1, 3));
        apply(3'd3, 32'h1234_5678, 1'b1, 8'h07, 8'h45, 2'd3);
        check("R1 reg-alt", observed(), model(3'd3, 32'h1234_5678, 1'b1, 5));
        apply(3'd1, 32'hCAFE_0001, 1'b0, 8'h25, 8'h00, 2'd0);
        check("R1 imm-masked", observed(), model(3'd1, 32'hCAFE_0001, 1'b0, 5));
        apply(3'd2, 32'hCAFE_0001, 1'b1, 8'h20, 8'h09, 2'd0);
        check("R1/R2 imm-masked-zero", observed(), {32'hCAFE_0001, 1'b0, 1'b1, 7'b0});
        apply(3'd5, 32'h8765_4321, 1'b1, 8'h01, 8'hC0, 2'd2);
        check("R1/R2 reg-masked-zero", observed(), {32'h8765_4321, 1'b0, 1'b1, 7'b0});

        // R9/R10: directed flag corner - shift left of top bit by one
        apply(3'd4, 32'h8000_0000, 1'b0, 8'h01, 8'h00, 2'd0);
        check("R9/R10 shl-to-zero", observed(), {32'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1});
        // R8: arithmetic right fill
        apply(3'd7, 32'h8000_0000, 1'b0, 8'h1F, 8'h00, 2'd0);
        check("R8 sar-fill", {observed()}[W+8:9], 32'hFFFF_FFFF);
        // R5: carry enters at bit n-1
        apply(3'd2, 32'h0, 1'b1, 8'h04, 8'h00, 2'd0);
        check("R5 rcl-carry-pos", {observed()}[W+8:9], 32'h0000_0008);
        // R6: carry enters at bit 32-n
        apply(3'd3, 32'h0, 1'b1, 8'h04, 8'h00, 2'd0);
        check("R6 rcr-carry-pos", {observed()}[W+8:9], 32'h1000_0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule